// File: doc/BRIEF.md
# Dual-Bank Address Translation Buffer

This block turns a 32-bit virtual address into a physical address through two direct-mapped translation caches. The top address bit picks the bank: when it is set, the system bank serves the lookup; otherwise the process bank does. Each slot keeps the full virtual page number as its tag, a page frame number, a per-mode permission mask and a dirty (modified) flag. A slot whose permission mask is all zero is empty, so no separate valid bit exists.

A request is taken when the block is idle. Two clock edges later either a translated address appears for one cycle, or a refill request is raised with the virtual address. The refill request stays up until an external walker answers with a new entry. The block then writes that entry into the indexed slot and completes the translation with it. With mapping disabled, the physical address is the virtual address cut to the physical width. A separate entry-write port preloads slots. Single-slot and whole-bank invalidation commands remove entries.

Top module: `addr_xlate`

## Requirements
- R1: After synchronous reset, `resp_valid` and `fill_req` are 0, and every slot of both banks is empty.
- R2: With `map_en`=0 at request time, the response arrives two edges after the request edge with `resp_pa` = `req_va[29:0]` and `resp_hit`=1. No refill is raised, whatever the mode mask.
- R3: `req_va[31]`=1 selects the system bank and 0 selects the process bank. `ent_sys`=1 writes the system bank.
- R4: The page offset is `va[8:0]`, the tag is `va[31:9]` and the slot index is `va[14:9]`. A lookup hits when the stored tag equals `va[31:9]` and (stored mask AND `req_mode`) is nonzero. On a hit, `resp_pa` = {pfn, `va[8:0]`}, `resp_hit`=1, two edges after the request edge.
- R5: A write lookup (`req_write`=1, `req_probe`=0) also misses when the stored dirty flag is 0. A probe (`req_probe`=1) ignores the dirty flag.
- R6: On a miss, `fill_req` rises one edge after the lookup cycle with `fill_va` = the request address. Both stay stable until `fill_done` is sampled, and `resp_valid` is 0 meanwhile.
- R7: When `fill_done` is sampled, the next cycle shows `resp_valid`=1, `resp_pa` = {`fill_pfn`, `va[8:0]`}, `resp_hit`=0 and `fill_req`=0. The entry (tag `va[31:9]`, `fill_pfn`, `fill_acc`, `fill_mod`) is installed in the slot, so the same lookup then hits.
- R8: `inv_all_sys` empties every system slot and `inv_all_proc` every process slot in one cycle. Neither touches the other bank.
- R9: `inv_one` empties slot `inv_idx` of the bank chosen by `inv_one_sys`. An invalidation wins over an entry write to the same slot in the same cycle.
- R10: A request presented while a lookup or refill is in progress is ignored. It yields no response and no refill.
- R11: `resp_valid` is a single-cycle pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_en | input | 1 | Translation enabled, sampled with the request |
| req_valid | input | 1 | Request strobe |
| req_va | input | 32 | Virtual address |
| req_mode | input | 4 | Requested mode mask |
| req_write | input | 1 | Write access |
| req_probe | input | 1 | Probe lookup, dirty flag not checked |
| resp_valid | output | 1 | Response pulse |
| resp_pa | output | 30 | Physical address |
| resp_hit | output | 1 | 1 when served without refill |
| fill_req | output | 1 | Refill wanted |
| fill_va | output | 32 | Address to refill |
| fill_done | input | 1 | Refill entry present |
| fill_pfn | input | 21 | Refill page frame number |
| fill_acc | input | 4 | Refill permission mask |
| fill_mod | input | 1 | Refill dirty flag |
| ent_we | input | 1 | Direct entry write |
| ent_sys | input | 1 | Entry write targets system bank |
| ent_idx | input | 6 | Entry write slot |
| ent_tag | input | 23 | Entry write tag |
| ent_pfn | input | 21 | Entry write frame number |
| ent_acc | input | 4 | Entry write permission mask |
| ent_mod | input | 1 | Entry write dirty flag |
| inv_all_sys | input | 1 | Empty the system bank |
| inv_all_proc | input | 1 | Empty the process bank |
| inv_one | input | 1 | Empty one slot |
| inv_one_sys | input | 1 | Single invalidate targets system bank |
| inv_idx | input | 6 | Slot to empty |

## Verification
The hardest situations to reach are the ones where two actions collide on the same slot in the same cycle: an invalidation together with a write, or a second request arriving while a refill is still open. Both depend on exact cycle alignment at the ports. The stimulus gets there by driving each input on the falling edge. The bench holds the refill open for several cycles while it injects a stray request, and it raises the entry write and the invalidate on one edge. The table of vectors then walks hit, permission miss, dirty miss, probe, bank and tag-mismatch cases. It restores the preloaded slots after every refill so that each vector starts from a known bank state.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_FILL = 2'd2
  } xlt_state_t;
endpackage

// File: rtl/xlt_bank.sv
module xlt_bank #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 23,
  parameter int PFN_W = 21,
  parameter int ACC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic [PFN_W-1:0] rd_pfn,
  output logic             rd_mod,
  output logic [ACC_W-1:0] rd_acc,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PFN_W-1:0] wr_pfn,
  input  logic             wr_mod,
  input  logic [ACC_W-1:0] wr_acc,
  input  logic             inv_all,
  input  logic             inv_one,
  input  logic [IDX_W-1:0] inv_idx
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int WORD_W = TAG_W + PFN_W + 1;

  // tag, frame and dirty flag: plain RAM, no reset, synchronous read
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_word;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_tag, wr_pfn, wr_mod};
    if (rd_en) rd_word <= mem[rd_idx];
  end

  assign {rd_tag, rd_pfn, rd_mod} = rd_word;

  // permission masks in flops so a whole bank can be emptied at once
  logic [ACC_W-1:0] acc_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) acc_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (inv_all || (inv_one && inv_idx == IDX_W'(i)))
          acc_q[i] <= '0;
        else if (wr_en && wr_idx == IDX_W'(i))
          acc_q[i] <= wr_acc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_acc <= '0;
    else if (rd_en) rd_acc <= acc_q[rd_idx];
  end

  logic live_any;
  always_comb begin
    live_any = 1'b0;
    for (int i = 0; i < DEPTH; i++) live_any = live_any | (|acc_q[i]);
  end

  AST_BANK_FLUSHED: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> !live_any); // R8

  AST_RESET_EMPTY: assert property (@(posedge clk)
    rst |=> !live_any); // R1
endmodule

// File: rtl/xlt_match.sv
module xlt_match #(
  parameter int TAG_W = 23,
  parameter int ACC_W = 4
) (
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [ACC_W-1:0] ent_acc,
  input  logic             ent_mod,
  input  logic [TAG_W-1:0] vpn,
  input  logic [ACC_W-1:0] mode,
  input  logic             need_mod,
  output logic             hit
);
  logic tag_eq;
  logic perm_ok;
  logic dirty_ok;

  always_comb begin
    tag_eq   = (ent_tag == vpn);
    perm_ok  = |(ent_acc & mode);
    dirty_ok = !need_mod || ent_mod;
    hit      = tag_eq && perm_ok && dirty_ok;
  end
endmodule

// File: rtl/xlt_ctrl.sv
module xlt_ctrl
  import xlt_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 30,
  parameter int OFF_W = 9,
  parameter int ACC_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_va,
  input  logic [ACC_W-1:0]       req_mode,
  input  logic                   req_write,
  input  logic                   req_probe,
  input  logic                   map_en,
  input  logic                   look_hit,
  input  logic [PA_W-OFF_W-1:0]  look_pfn,
  input  logic                   fill_done,
  input  logic [PA_W-OFF_W-1:0]  fill_pfn,
  output logic                   accept,
  output logic [VA_W-1:0]        va_q,
  output logic [ACC_W-1:0]       mode_q,
  output logic                   need_mod,
  output logic                   fill_wr,
  output logic                   resp_valid,
  output logic [PA_W-1:0]        resp_pa,
  output logic                   resp_hit,
  output logic                   fill_req,
  output logic [VA_W-1:0]        fill_va
);
  xlt_state_t st;
  logic wr_q, probe_q, map_q;

  assign accept   = (st == ST_IDLE) && req_valid;
  assign need_mod = wr_q && !probe_q;
  assign fill_wr  = (st == ST_FILL) && fill_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      va_q       <= '0;
      mode_q     <= '0;
      wr_q       <= 1'b0;
      probe_q    <= 1'b0;
      map_q      <= 1'b0;
      resp_valid <= 1'b0;
      resp_pa    <= '0;
      resp_hit   <= 1'b0;
      fill_req   <= 1'b0;
      fill_va    <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          va_q    <= req_va;
          mode_q  <= req_mode;
          wr_q    <= req_write;
          probe_q <= req_probe;
          map_q   <= map_en;
          st      <= ST_LOOK;
        end
        ST_LOOK: begin
          if (!map_q) begin
            resp_valid <= 1'b1;
            resp_pa    <= va_q[PA_W-1:0];
            resp_hit   <= 1'b1;
            st         <= ST_IDLE;
          end else if (look_hit) begin
            resp_valid <= 1'b1;
            resp_pa    <= {look_pfn, va_q[OFF_W-1:0]};
            resp_hit   <= 1'b1;
            st         <= ST_IDLE;
          end else begin
            fill_req <= 1'b1;
            fill_va  <= va_q;
            st       <= ST_FILL;
          end
        end
        ST_FILL: if (fill_done) begin
          fill_req   <= 1'b0;
          resp_valid <= 1'b1;
          resp_pa    <= {fill_pfn, va_q[OFF_W-1:0]};
          resp_hit   <= 1'b0;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_FILL_HELD: assert property (@(posedge clk) disable iff (rst)
    fill_req && !fill_done |=> fill_req && $stable(fill_va)); // R6

  AST_FILL_QUIET: assert property (@(posedge clk) disable iff (rst)
    fill_req |-> !resp_valid); // R6

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid); // R11

  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) && req_valid |=> $stable(va_q)); // R10

  AST_FILL_MAPPED: assert property (@(posedge clk) disable iff (rst)
    fill_req |-> map_q); // R2
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 30,
  parameter int OFF_W = 9,
  parameter int IDX_W = 6,
  parameter int ACC_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  map_en,
  input  logic                  req_valid,
  input  logic [VA_W-1:0]       req_va,
  input  logic [ACC_W-1:0]      req_mode,
  input  logic                  req_write,
  input  logic                  req_probe,
  output logic                  resp_valid,
  output logic [PA_W-1:0]       resp_pa,
  output logic                  resp_hit,
  output logic                  fill_req,
  output logic [VA_W-1:0]       fill_va,
  input  logic                  fill_done,
  input  logic [PA_W-OFF_W-1:0] fill_pfn,
  input  logic [ACC_W-1:0]      fill_acc,
  input  logic                  fill_mod,
  input  logic                  ent_we,
  input  logic                  ent_sys,
  input  logic [IDX_W-1:0]      ent_idx,
  input  logic [VA_W-OFF_W-1:0] ent_tag,
  input  logic [PA_W-OFF_W-1:0] ent_pfn,
  input  logic [ACC_W-1:0]      ent_acc,
  input  logic                  ent_mod,
  input  logic                  inv_all_sys,
  input  logic                  inv_all_proc,
  input  logic                  inv_one,
  input  logic                  inv_one_sys,
  input  logic [IDX_W-1:0]      inv_idx
);
  localparam int TAG_W  = VA_W - OFF_W;
  localparam int PFN_W  = PA_W - OFF_W;
  localparam int NBANK  = 2;

  logic             accept, need_mod, fill_wr, look_hit;
  logic [VA_W-1:0]  va_q;
  logic [ACC_W-1:0] mode_q;
  logic [IDX_W-1:0] rd_idx;
  logic             sel_sys;

  logic [TAG_W-1:0] bk_tag [NBANK];
  logic [PFN_W-1:0] bk_pfn [NBANK];
  logic             bk_mod [NBANK];
  logic [ACC_W-1:0] bk_acc [NBANK];

  assign rd_idx  = req_va[OFF_W +: IDX_W];
  assign sel_sys = va_q[VA_W-1];

  // bank 1 serves the system region, bank 0 the process regions
  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    localparam logic IS_SYS = (g == 1);
    logic             fill_here, ent_here, w_en, a_all, a_one;
    logic [IDX_W-1:0] w_idx;
    logic [TAG_W-1:0] w_tag;
    logic [PFN_W-1:0] w_pfn;
    logic             w_mod;
    logic [ACC_W-1:0] w_acc;

    always_comb begin
      fill_here = fill_wr && (sel_sys == IS_SYS);
      ent_here  = ent_we && (ent_sys == IS_SYS);
      w_en      = fill_here || ent_here;
      if (fill_here) begin
        w_idx = va_q[OFF_W +: IDX_W];
        w_tag = va_q[VA_W-1:OFF_W];
        w_pfn = fill_pfn;
        w_mod = fill_mod;
        w_acc = fill_acc;
      end else begin
        w_idx = ent_idx;
        w_tag = ent_tag;
        w_pfn = ent_pfn;
        w_mod = ent_mod;
        w_acc = ent_acc;
      end
      a_all = IS_SYS ? inv_all_sys : inv_all_proc;
      a_one = inv_one && (inv_one_sys == IS_SYS);
    end

    xlt_bank #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PFN_W(PFN_W), .ACC_W(ACC_W)) u_bank (
      .clk(clk), .rst(rst),
      .rd_en(accept), .rd_idx(rd_idx),
      .rd_tag(bk_tag[g]), .rd_pfn(bk_pfn[g]), .rd_mod(bk_mod[g]), .rd_acc(bk_acc[g]),
      .wr_en(w_en), .wr_idx(w_idx), .wr_tag(w_tag), .wr_pfn(w_pfn),
      .wr_mod(w_mod), .wr_acc(w_acc),
      .inv_all(a_all), .inv_one(a_one), .inv_idx(inv_idx)
    );
  end

  xlt_match #(.TAG_W(TAG_W), .ACC_W(ACC_W)) u_match (
    .ent_tag(bk_tag[sel_sys]), .ent_acc(bk_acc[sel_sys]), .ent_mod(bk_mod[sel_sys]),
    .vpn(va_q[VA_W-1:OFF_W]), .mode(mode_q), .need_mod(need_mod), .hit(look_hit)
  );

  xlt_ctrl #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .ACC_W(ACC_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_va(req_va), .req_mode(req_mode),
    .req_write(req_write), .req_probe(req_probe), .map_en(map_en),
    .look_hit(look_hit), .look_pfn(bk_pfn[sel_sys]),
    .fill_done(fill_done), .fill_pfn(fill_pfn),
    .accept(accept), .va_q(va_q), .mode_q(mode_q), .need_mod(need_mod),
    .fill_wr(fill_wr),
    .resp_valid(resp_valid), .resp_pa(resp_pa), .resp_hit(resp_hit),
    .fill_req(fill_req), .fill_va(fill_va)
  );

  AST_REFILL_ANSWER: assert property (@(posedge clk) disable iff (rst)
    fill_req && fill_done |=> resp_valid && !resp_hit && !fill_req); // R7
endmodule

// File: tb/tb_addr_xlate.sv
module tb_addr_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        map_en = 1'b0, req_valid = 1'b0, req_write = 1'b0, req_probe = 1'b0;
  logic [31:0] req_va = '0;
  logic [3:0]  req_mode = '0;
  logic        resp_valid, resp_hit, fill_req;
  logic [29:0] resp_pa;
  logic [31:0] fill_va;
  logic        fill_done = 1'b0, fill_mod = 1'b0;
  logic [20:0] fill_pfn = '0;
  logic [3:0]  fill_acc = '0;
  logic        ent_we = 1'b0, ent_sys = 1'b0, ent_mod = 1'b0;
  logic [5:0]  ent_idx = '0, inv_idx = '0;
  logic [22:0] ent_tag = '0;
  logic [20:0] ent_pfn = '0;
  logic [3:0]  ent_acc = '0;
  logic        inv_all_sys = 1'b0, inv_all_proc = 1'b0, inv_one = 1'b0, inv_one_sys = 1'b0;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  addr_xlate dut (
    .clk(clk), .rst(rst), .map_en(map_en), .req_valid(req_valid), .req_va(req_va),
    .req_mode(req_mode), .req_write(req_write), .req_probe(req_probe),
    .resp_valid(resp_valid), .resp_pa(resp_pa), .resp_hit(resp_hit),
    .fill_req(fill_req), .fill_va(fill_va), .fill_done(fill_done),
    .fill_pfn(fill_pfn), .fill_acc(fill_acc), .fill_mod(fill_mod),
    .ent_we(ent_we), .ent_sys(ent_sys), .ent_idx(ent_idx), .ent_tag(ent_tag),
    .ent_pfn(ent_pfn), .ent_acc(ent_acc), .ent_mod(ent_mod),
    .inv_all_sys(inv_all_sys), .inv_all_proc(inv_all_proc),
    .inv_one(inv_one), .inv_one_sys(inv_one_sys), .inv_idx(inv_idx)
  );

  typedef struct packed {
    logic [31:0] va;
    logic [3:0]  mode;
    logic        wr;
    logic        probe;
    logic        map;
    logic        miss;
    logic [29:0] pa;
    logic [3:0]  rq;
  } vec_t;

  // misses are answered with frame 0x777, so their address is {0x777, offset}
  localparam vec_t VEC [10] = '{
    '{32'h0000_2455, 4'b0001, 1'b0, 1'b0, 1'b1, 1'b0, 30'h0015_7855, 4'd4}, // R4 hit
    '{32'h0000_2455, 4'b0100, 1'b0, 1'b0, 1'b1, 1'b1, 30'h000E_EE55, 4'd4}, // R4 mode miss
    '{32'h0000_2455, 4'b0001, 1'b1, 1'b0, 1'b1, 1'b1, 30'h000E_EE55, 4'd5}, // R5 clean write
    '{32'h0000_2455, 4'b0001, 1'b1, 1'b1, 1'b1, 1'b0, 30'h0015_7855, 4'd5}, // R5 probe
    '{32'h8000_07FF, 4'b1000, 1'b0, 1'b0, 1'b1, 1'b0, 30'h03E0_1FFF, 4'd3}, // R3 system hit
    '{32'h8000_07FF, 4'b1000, 1'b1, 1'b0, 1'b1, 1'b0, 30'h03E0_1FFF, 4'd5}, // R5 dirty write
    '{32'h0000_0600, 4'b1000, 1'b0, 1'b0, 1'b1, 1'b1, 30'h000E_EE00, 4'd3}, // R3 process side
    '{32'h8000_2455, 4'b0011, 1'b0, 1'b0, 1'b1, 1'b1, 30'h000E_EE55, 4'd3}, // R3 system side
    '{32'h0800_2455, 4'b0001, 1'b0, 1'b0, 1'b1, 1'b1, 30'h000E_EE55, 4'd4}, // R4 tag mismatch
    '{32'hC123_4567, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 30'h0123_4567, 4'd2}  // R2 unmapped
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] va, input logic [3:0] mode, input logic wr,
                      input logic probe, input logic map);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_mode = mode;
    req_write = wr; req_probe = probe; map_en = map;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic serve(input logic [20:0] pfn, input logic [3:0] acc, input logic md);
    fill_done = 1'b1; fill_pfn = pfn; fill_acc = acc; fill_mod = md;
    @(negedge clk);
    fill_done = 1'b0;
  endtask

  task automatic put(input logic sys, input logic [5:0] idx, input logic [22:0] tag,
                     input logic [20:0] pfn, input logic [3:0] acc, input logic md);
    @(negedge clk);
    ent_we = 1'b1; ent_sys = sys; ent_idx = idx; ent_tag = tag;
    ent_pfn = pfn; ent_acc = acc; ent_mod = md;
    @(negedge clk);
    ent_we = 1'b0;
  endtask

  task automatic preload();
    put(1'b0, 6'h12, 23'h00_0012, 21'h00ABC, 4'b0011, 1'b0);
    put(1'b1, 6'h03, 23'h40_0003, 21'h1F00F, 4'b1000, 1'b1);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 resp_valid after reset", 32'(resp_valid), 32'd0);
    check("R1 fill_req after reset", 32'(fill_req), 32'd0);
    // R1: an empty process slot misses
    send(32'h0000_2455, 4'b1111, 1'b0, 1'b0, 1'b1);
    check("R1 empty slot misses", 32'(fill_req), 32'd1);
    serve(21'h0, 4'b0000, 1'b0);

    preload();
    for (int i = 0; i < 10; i++) begin
      send(VEC[i].va, VEC[i].mode, VEC[i].wr, VEC[i].probe, VEC[i].map);
      if (VEC[i].miss) begin
        check($sformatf("R%0d vec%0d fill_req", VEC[i].rq, i), 32'(fill_req), 32'd1);
        check($sformatf("R6 vec%0d fill_va", i), fill_va, VEC[i].va);
        serve(21'h00777, 4'b1111, 1'b1);
        check($sformatf("R7 vec%0d resp_valid", i), 32'(resp_valid), 32'd1);
        check($sformatf("R7 vec%0d resp_pa", i), 32'(resp_pa), 32'(VEC[i].pa));
        check($sformatf("R7 vec%0d resp_hit", i), 32'(resp_hit), 32'd0);
        preload();
      end else begin
        check($sformatf("R%0d vec%0d resp_valid", VEC[i].rq, i), 32'(resp_valid), 32'd1);
        check($sformatf("R%0d vec%0d resp_pa", VEC[i].rq, i), 32'(resp_pa), 32'(VEC[i].pa));
        check($sformatf("R%0d vec%0d resp_hit", VEC[i].rq, i), 32'(resp_hit), 32'd1);
        check($sformatf("R%0d vec%0d no fill", VEC[i].rq, i), 32'(fill_req), 32'd0);
      end
    end

    // R6 hold, R10 stray request during refill, R7 install, R11 pulse
    send(32'h0000_4A10, 4'b0010, 1'b0, 1'b0, 1'b1);
    check("R6 miss raises fill", 32'(fill_req), 32'd1);
    for (int k = 0; k < 4; k++) begin
      req_valid = (k == 1); req_va = 32'h0000_0000;
      @(negedge clk);
      check("R6 fill held", 32'(fill_req), 32'd1);
      check("R6 fill_va held", fill_va, 32'h0000_4A10);
      check("R6 no response while open", 32'(resp_valid), 32'd0);
    end
    req_valid = 1'b0;
    serve(21'h12345, 4'b0010, 1'b0);
    check("R7 refill pa", 32'(resp_pa), 32'h0246_8A10);
    check("R7 refill flagged", 32'(resp_hit), 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 stray request ignored", 32'(resp_valid | fill_req), 32'd0);
    end
    send(32'h0000_4A10, 4'b0010, 1'b0, 1'b0, 1'b1);
    check("R7 installed entry hits", 32'(resp_hit & resp_valid), 32'd1);
    check("R7 installed pa", 32'(resp_pa), 32'h0246_8A10);
    @(negedge clk);
    check("R11 single-cycle response", 32'(resp_valid), 32'd0);

    // R9 single invalidate
    @(negedge clk);
    inv_one = 1'b1; inv_one_sys = 1'b0; inv_idx = 6'h25;
    @(negedge clk);
    inv_one = 1'b0;
    send(32'h0000_4A10, 4'b0010, 1'b0, 1'b0, 1'b1);
    check("R9 invalidated slot misses", 32'(fill_req), 32'd1);
    serve(21'h12345, 4'b0010, 1'b0);

    // R9 invalidate beats a same-cycle write to that slot
    @(negedge clk);
    ent_we = 1'b1; ent_sys = 1'b0; ent_idx = 6'h25; ent_tag = 23'h25;
    ent_pfn = 21'h00111; ent_acc = 4'b0010; ent_mod = 1'b1;
    inv_one = 1'b1; inv_one_sys = 1'b0; inv_idx = 6'h25;
    @(negedge clk);
    ent_we = 1'b0; inv_one = 1'b0;
    send(32'h0000_4A10, 4'b0010, 1'b0, 1'b0, 1'b1);
    check("R9 invalidate wins over write", 32'(fill_req), 32'd1);
    serve(21'h12345, 4'b0010, 1'b0);

    // R8 process flush leaves system bank alone
    preload();
    @(negedge clk);
    inv_all_proc = 1'b1;
    @(negedge clk);
    inv_all_proc = 1'b0;
    send(32'h8000_07FF, 4'b1000, 1'b0, 1'b0, 1'b1);
    check("R8 system bank kept", 32'(resp_valid & resp_hit), 32'd1);
    send(32'h0000_2455, 4'b0001, 1'b0, 1'b0, 1'b1);
    check("R8 process bank flushed", 32'(fill_req), 32'd1);
    serve(21'h00777, 4'b0001, 1'b0);
    @(negedge clk);
    inv_all_sys = 1'b1;
    @(negedge clk);
    inv_all_sys = 1'b0;
    send(32'h8000_07FF, 4'b1000, 1'b0, 1'b0, 1'b1);
    check("R8 system bank flushed", 32'(fill_req), 32'd1);
    serve(21'h00777, 4'b1000, 1'b0);
    send(32'h0000_2455, 4'b0001, 1'b0, 1'b0, 1'b1);
    check("R8 process refill kept", 32'(resp_valid & resp_hit), 32'd1);

    summary();
    $finish;
  end
endmodule